// File: doc/BRIEF.md
# Sorted Key-Value Set Operation Engine

This block merges two ascending lists of key-value pairs, held in two source buffers, into a third ascending list held in a result buffer. A controller fills the source buffers through a single write port and gives the number of valid entries in each. It then starts one operation. The merging operations are union, intersection and difference (the first source minus the second). The slice operations pick entries of the first source by comparing each key with a bound key.

The engine looks at the head entry of each source once per clock. In each step it writes at most one pair to the result buffer, so the result comes out already in order. When the operation ends, a one-cycle completion pulse is raised and the number of result pairs is reported. If the result buffer is full and another pair is still due, the operation stops and an overflow flag is raised. A controller can then drain the buffer and continue with a later block. The result buffer is read through a combinational read port. Both source lines must be strictly ascending and unsigned-ordered.

Top module: `sortset_engine`

## Requirements
- R1: After reset, busy, done, overflow and the result count are all zero.
- R2: A source write while idle stores key and value at the given index, into source A when the select bit is 0 and into source B when it is 1. A source write while busy is ignored.
- R3: Opcode 0 (union) outputs every key found in A or B once. On a key present in both, the value from A is kept.
- R4: Opcode 1 (intersection) outputs only the keys present in both sources, each with its A value.
- R5: Opcode 2 (difference) outputs the keys of A that are absent from B, with their A values.
- R6: The slice opcodes output the entries of A whose key is, against the bound: 3 strictly less, 4 strictly greater, 5 less or equal, 6 greater or equal. Opcode 7 produces an empty result.
- R7: A start seen while idle makes busy rise at the next edge. Each busy cycle performs one step that advances at least one source head and writes at most one pair. The last step is the one that finds nothing more to do. done is high for exactly one cycle right after the last step, with busy low.
- R8: If a pair is due while the result buffer already holds RES_DEPTH pairs, the operation ends in that step. The pair is not written, overflow is set until the next start, and the count stays at RES_DEPTH. If the buffer fills exactly with the final pair, no overflow is raised.
- R9: A start asserted while busy is ignored, and the running operation completes unchanged.
- R10: The result read port returns, combinationally, the key and value at the given index. The entries below the result count are strictly ascending by key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srcWrEn | input | 1 | Source buffer write strobe |
| srcWrSel | input | 1 | Source select: 0 = A, 1 = B |
| srcWrIdx | input | 3 | Entry index in the selected source |
| srcWrKey | input | 32 | Key to store |
| srcWrVal | input | 32 | Value to store |
| start | input | 1 | Begin an operation (taken only while idle) |
| opSel | input | 3 | Operation code, see R3 to R6 |
| lenA | input | 4 | Valid entries in A, latched at start |
| lenB | input | 4 | Valid entries in B, latched at start |
| boundKey | input | 32 | Slice bound, latched at start |
| resRdIdx | input | 3 | Result read index |
| resRdKey | output | 32 | Result key at the read index |
| resRdVal | output | 32 | Result value at the read index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| resCount | output | 4 | Pairs written to the result buffer |
| overflow | output | 1 | Result buffer ran out before completion |

## Verification
A wrong head index or a wrong compare decision shows up in the result read port as a missing, duplicated or misordered key. The same fault also changes the number of steps, so busy falls and done pulses in the wrong cycle. Because busy and done are compared against the model on every clock, a timing error is caught at the first cycle it occurs. Value-selection faults on equal keys show up only as a wrong value at the read port once done rises. Overflow faults show up as a wrong count or a flag that differs at that same pulse.

// File: rtl/sortset_pkg.sv
package sortset_pkg;

  typedef enum logic [2:0] {
    OP_UNION = 3'd0,
    OP_AND   = 3'd1,
    OP_DIFF  = 3'd2,
    OP_LT    = 3'd3,
    OP_GT    = 3'd4,
    OP_LE    = 3'd5,
    OP_GE    = 3'd6,
    OP_NONE  = 3'd7
  } setOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic advA;
    logic advB;
    logic emitA;
    logic emitB;
    logic finish;
    logic setOvf;
  } ctlStrobe_t;

endpackage

// File: rtl/sortset_dp.sv
module sortset_dp
  import sortset_pkg::*;
#(
  parameter int KEY_W     = 32,
  parameter int VAL_W     = 32,
  parameter int SRC_DEPTH = 8,
  parameter int RES_DEPTH = 8,
  localparam int SIDX_W   = $clog2(SRC_DEPTH),
  localparam int SCNT_W   = $clog2(SRC_DEPTH + 1),
  localparam int RIDX_W   = $clog2(RES_DEPTH),
  localparam int RCNT_W   = $clog2(RES_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        stb,
  input  logic              idle,
  input  logic              srcWrEn,
  input  logic              srcWrSel,
  input  logic [SIDX_W-1:0] srcWrIdx,
  input  logic [KEY_W-1:0]  srcWrKey,
  input  logic [VAL_W-1:0]  srcWrVal,
  input  logic [SCNT_W-1:0] startLenA,
  input  logic [SCNT_W-1:0] startLenB,
  output logic [KEY_W-1:0]  headKeyA,
  output logic [KEY_W-1:0]  headKeyB,
  output logic              headValidA,
  output logic              headValidB,
  output logic              resFull,
  input  logic [RIDX_W-1:0] resRdIdx,
  output logic [KEY_W-1:0]  resRdKey,
  output logic [VAL_W-1:0]  resRdVal,
  output logic [RCNT_W-1:0] resCount,
  output logic              ovfFlag
);

  logic [SCNT_W-1:0] idxA, idxB, lenA, lenB;
  logic [RCNT_W-1:0] rCnt;
  logic [VAL_W-1:0]  headValA, headValB;
  logic [KEY_W-1:0]  wrKey;
  logic [VAL_W-1:0]  wrVal;
  logic              wrEn;

  // two identical source banks
  for (genvar s = 0; s < 2; s++) begin : g_src
    logic [KEY_W-1:0] key [SRC_DEPTH];
    logic [VAL_W-1:0] val [SRC_DEPTH];
    always_ff @(posedge clk) begin
      if (srcWrEn && idle && (srcWrSel == 1'(s))) begin
        key[srcWrIdx] <= srcWrKey;
        val[srcWrIdx] <= srcWrVal;
      end
    end
  end

  assign headKeyA   = g_src[0].key[idxA[SIDX_W-1:0]];
  assign headValA   = g_src[0].val[idxA[SIDX_W-1:0]];
  assign headKeyB   = g_src[1].key[idxB[SIDX_W-1:0]];
  assign headValB   = g_src[1].val[idxB[SIDX_W-1:0]];
  assign headValidA = idxA < lenA;
  assign headValidB = idxB < lenB;
  assign resFull    = rCnt == RCNT_W'(RES_DEPTH);

  // result buffer
  logic [KEY_W-1:0] rKey [RES_DEPTH];
  logic [VAL_W-1:0] rVal [RES_DEPTH];

  assign wrEn  = stb.emitA || stb.emitB;
  assign wrKey = stb.emitA ? headKeyA : headKeyB;
  assign wrVal = stb.emitA ? headValA : headValB;

  always_ff @(posedge clk) begin
    if (wrEn) begin
      rKey[rCnt[RIDX_W-1:0]] <= wrKey;
      rVal[rCnt[RIDX_W-1:0]] <= wrVal;
    end
  end

  assign resRdKey = rKey[resRdIdx];
  assign resRdVal = rVal[resRdIdx];
  assign resCount = rCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxA    <= '0;
      idxB    <= '0;
      lenA    <= '0;
      lenB    <= '0;
      rCnt    <= '0;
      ovfFlag <= 1'b0;
    end else if (stb.clear) begin
      idxA    <= '0;
      idxB    <= '0;
      lenA    <= (startLenA > SCNT_W'(SRC_DEPTH)) ? SCNT_W'(SRC_DEPTH) : startLenA;
      lenB    <= (startLenB > SCNT_W'(SRC_DEPTH)) ? SCNT_W'(SRC_DEPTH) : startLenB;
      rCnt    <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (stb.advA) idxA <= idxA + 1'b1;
      if (stb.advB) idxB <= idxB + 1'b1;
      if (wrEn)     rCnt <= rCnt + 1'b1;
      if (stb.setOvf) ovfFlag <= 1'b1;
    end
  end

  AST_ONE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.emitA && stb.emitB)); // R7
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    resFull |-> !wrEn); // R8
  AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovfFlag |-> resFull); // R8
  AST_RESULT_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && rCnt != '0) |-> (wrKey > rKey[RIDX_W'(rCnt - 1'b1)])); // R10
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.clear && !wrEn) |=> $stable(rCnt)); // R7

endmodule

// File: rtl/sortset_ctl.sv
module sortset_ctl
  import sortset_pkg::*;
#(
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       opSel,
  input  logic [KEY_W-1:0] boundKey,
  input  logic [KEY_W-1:0] headKeyA,
  input  logic [KEY_W-1:0] headKeyB,
  input  logic             headValidA,
  input  logic             headValidB,
  input  logic             resFull,
  output ctlStrobe_t       stb,
  output logic             idle,
  output logic             busy,
  output logic             done
);

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_e;

  ctlState_e        state, nextState;
  setOp_e           opReg;
  logic [KEY_W-1:0] boundReg;
  logic             wantA, wantB, advA, advB, fin, slicePass;
  logic             aLtB, aEqB;

  assign aLtB = headKeyA < headKeyB;
  assign aEqB = headKeyA == headKeyB;
  assign idle = state == ST_IDLE;
  assign busy = state == ST_RUN;

  always_comb begin
    unique case (opReg)
      OP_LT:   slicePass = headKeyA <  boundReg;
      OP_GT:   slicePass = headKeyA >  boundReg;
      OP_LE:   slicePass = headKeyA <= boundReg;
      OP_GE:   slicePass = headKeyA >= boundReg;
      default: slicePass = 1'b0;
    endcase
  end

  // one merge decision per clock
  always_comb begin
    wantA = 1'b0; wantB = 1'b0; advA = 1'b0; advB = 1'b0; fin = 1'b0;
    unique case (opReg)
      OP_UNION: begin
        if (headValidA && headValidB) begin
          if (aLtB)      begin wantA = 1'b1; advA = 1'b1; end
          else if (aEqB) begin wantA = 1'b1; advA = 1'b1; advB = 1'b1; end
          else           begin wantB = 1'b1; advB = 1'b1; end
        end else if (headValidA) begin wantA = 1'b1; advA = 1'b1; end
        else if (headValidB)     begin wantB = 1'b1; advB = 1'b1; end
        else fin = 1'b1;
      end
      OP_AND: begin
        if (headValidA && headValidB) begin
          if (aLtB)      advA = 1'b1;
          else if (aEqB) begin wantA = 1'b1; advA = 1'b1; advB = 1'b1; end
          else           advB = 1'b1;
        end else fin = 1'b1;
      end
      OP_DIFF: begin
        if (headValidA && headValidB) begin
          if (aLtB)      begin wantA = 1'b1; advA = 1'b1; end
          else if (aEqB) begin advA = 1'b1; advB = 1'b1; end
          else           advB = 1'b1;
        end else if (headValidA) begin wantA = 1'b1; advA = 1'b1; end
        else fin = 1'b1;
      end
      OP_LT, OP_GT, OP_LE, OP_GE: begin
        if (headValidA) begin wantA = slicePass; advA = 1'b1; end
        else fin = 1'b1;
      end
      default: fin = 1'b1;
    endcase
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.clear = 1'b1;
          nextState = ST_RUN;
        end
      end
      ST_RUN: begin
        if ((wantA || wantB) && resFull) begin
          stb.finish = 1'b1;
          stb.setOvf = 1'b1;
        end else begin
          stb.emitA  = wantA;
          stb.emitB  = wantB;
          stb.advA   = advA;
          stb.advB   = advB;
          stb.finish = fin;
        end
        if (stb.finish) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      opReg    <= OP_NONE;
      boundReg <= '0;
      done     <= 1'b0;
    end else begin
      state <= nextState;
      done  <= busy && stb.finish;
      if (stb.clear) begin
        opReg    <= setOp_e'(opSel);
        boundReg <= boundKey;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> busy); // R7
  AST_RUN_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stb.finish) |-> (stb.advA || stb.advB)); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(opReg)); // R9

endmodule

// File: rtl/sortset_engine.sv
module sortset_engine
  import sortset_pkg::*;
#(
  parameter int KEY_W     = 32,
  parameter int VAL_W     = 32,
  parameter int SRC_DEPTH = 8,
  parameter int RES_DEPTH = 8,
  localparam int SIDX_W   = $clog2(SRC_DEPTH),
  localparam int SCNT_W   = $clog2(SRC_DEPTH + 1),
  localparam int RIDX_W   = $clog2(RES_DEPTH),
  localparam int RCNT_W   = $clog2(RES_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srcWrEn,
  input  logic              srcWrSel,
  input  logic [SIDX_W-1:0] srcWrIdx,
  input  logic [KEY_W-1:0]  srcWrKey,
  input  logic [VAL_W-1:0]  srcWrVal,
  input  logic              start,
  input  logic [2:0]        opSel,
  input  logic [SCNT_W-1:0] lenA,
  input  logic [SCNT_W-1:0] lenB,
  input  logic [KEY_W-1:0]  boundKey,
  input  logic [RIDX_W-1:0] resRdIdx,
  output logic [KEY_W-1:0]  resRdKey,
  output logic [VAL_W-1:0]  resRdVal,
  output logic              busy,
  output logic              done,
  output logic [RCNT_W-1:0] resCount,
  output logic              overflow
);

  ctlStrobe_t       stb;
  logic             idle, headValidA, headValidB, resFull;
  logic [KEY_W-1:0] headKeyA, headKeyB;

  sortset_ctl #(.KEY_W(KEY_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .opSel(opSel), .boundKey(boundKey),
    .headKeyA(headKeyA), .headKeyB(headKeyB), .headValidA(headValidA),
    .headValidB(headValidB), .resFull(resFull), .stb(stb), .idle(idle),
    .busy(busy), .done(done)
  );

  sortset_dp #(.KEY_W(KEY_W), .VAL_W(VAL_W), .SRC_DEPTH(SRC_DEPTH),
               .RES_DEPTH(RES_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .idle(idle), .srcWrEn(srcWrEn),
    .srcWrSel(srcWrSel), .srcWrIdx(srcWrIdx), .srcWrKey(srcWrKey),
    .srcWrVal(srcWrVal), .startLenA(lenA), .startLenB(lenB),
    .headKeyA(headKeyA), .headKeyB(headKeyB), .headValidA(headValidA),
    .headValidB(headValidB), .resFull(resFull), .resRdIdx(resRdIdx),
    .resRdKey(resRdKey), .resRdVal(resRdVal), .resCount(resCount),
    .ovfFlag(overflow)
  );

endmodule

// File: tb/sortset_engine_tb.sv
`timescale 1ns/100ps
module sortset_engine_tb;

  localparam int RD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srcWrEn = 1'b0, srcWrSel = 1'b0;
  logic [2:0]  srcWrIdx = '0;
  logic [31:0] srcWrKey = '0, srcWrVal = '0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic [3:0]  lenA = '0, lenB = '0;
  logic [31:0] boundKey = '0;
  logic [2:0]  resRdIdx = '0;
  logic [31:0] resRdKey, resRdVal;
  logic        busy, done, overflow;
  logic [3:0]  resCount;

  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  sortset_engine u_dut (
    .clk(clk), .rst_n(rst_n), .srcWrEn(srcWrEn), .srcWrSel(srcWrSel),
    .srcWrIdx(srcWrIdx), .srcWrKey(srcWrKey), .srcWrVal(srcWrVal),
    .start(start), .opSel(opSel), .lenA(lenA), .lenB(lenB), .boundKey(boundKey),
    .resRdIdx(resRdIdx), .resRdKey(resRdKey), .resRdVal(resRdVal),
    .busy(busy), .done(done), .resCount(resCount), .overflow(overflow)
  );

  // behavioural model state
  logic [31:0] mAk [8], mAv [8], mBk [8], mBv [8];
  logic [31:0] expK [$], expV [$];
  bit          expOvf;
  int          expSteps;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic loadSrc(input bit sel, input int idx, input logic [31:0] k,
                         input logic [31:0] v);
    @(negedge clk);
    srcWrEn = 1'b1; srcWrSel = sel; srcWrIdx = 3'(idx); srcWrKey = k; srcWrVal = v;
    @(negedge clk);
    srcWrEn = 1'b0;
    if (sel) begin mBk[idx] = k; mBv[idx] = v; end
    else     begin mAk[idx] = k; mAv[idx] = v; end
  endtask

  function automatic bit passes(input int op, input logic [31:0] k,
                                input logic [31:0] b);
    case (op)
      3: return k <  b;
      4: return k >  b;
      5: return k <= b;
      6: return k >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model(input int op, input int la, input int lb,
                       input logic [31:0] bound);
    int ia = 0, ib = 0;
    expK.delete(); expV.delete(); expOvf = 1'b0; expSteps = 0;
    while (1) begin
      bit av = ia < la, bv = ib < lb;
      bit wa = 0, wb = 0, fa = 0, fb = 0, fin = 0;
      expSteps++;
      if (op == 0) begin
        if (av && bv) begin
          if (mAk[ia] < mBk[ib]) begin wa = 1; fa = 1; end
          else if (mAk[ia] == mBk[ib]) begin wa = 1; fa = 1; fb = 1; end
          else begin wb = 1; fb = 1; end
        end else if (av) begin wa = 1; fa = 1; end
        else if (bv) begin wb = 1; fb = 1; end
        else fin = 1;
      end else if (op == 1) begin
        if (av && bv) begin
          if (mAk[ia] < mBk[ib]) fa = 1;
          else if (mAk[ia] == mBk[ib]) begin wa = 1; fa = 1; fb = 1; end
          else fb = 1;
        end else fin = 1;
      end else if (op == 2) begin
        if (av && bv) begin
          if (mAk[ia] < mBk[ib]) begin wa = 1; fa = 1; end
          else if (mAk[ia] == mBk[ib]) begin fa = 1; fb = 1; end
          else fb = 1;
        end else if (av) begin wa = 1; fa = 1; end
        else fin = 1;
      end else if (op >= 3 && op <= 6) begin
        if (av) begin wa = passes(op, mAk[ia], bound); fa = 1; end
        else fin = 1;
      end else fin = 1;
      if ((wa || wb) && expK.size() == RD) begin expOvf = 1; break; end
      if (fin) break;
      if (wa) begin expK.push_back(mAk[ia]); expV.push_back(mAv[ia]); end
      if (wb) begin expK.push_back(mBk[ib]); expV.push_back(mBv[ib]); end
      ia += int'(fa); ib += int'(fb);
    end
  endtask

  // run one operation, comparing busy/done every clock, then the result line
  task automatic runOp(input string req, input int op, input int la, input int lb,
                       input logic [31:0] bound, input bit disturb);
    model(op, la, lb, bound);
    @(negedge clk);
    start = 1'b1; opSel = 3'(op); lenA = 4'(la); lenB = 4'(lb); boundKey = bound;
    @(posedge clk);
    for (int j = 0; j <= expSteps + 1; j++) begin
      @(negedge clk);
      start = 1'b0;
      if (disturb && j == 1) begin
        start = 1'b1; opSel = 3'd7;          // R9 start while busy
        srcWrEn = 1'b1; srcWrSel = 1'b0;     // R2 write while busy
        srcWrIdx = 3'd0; srcWrKey = 32'hFFFF_FFF0; srcWrVal = 32'hDEAD;
      end else begin
        srcWrEn = 1'b0;
      end
      chk(busy == (j < expSteps), {req, " R7 busy"}, 32'(busy), 32'(j < expSteps));
      chk(done == (j == expSteps), {req, " R7 done"}, 32'(done), 32'(j == expSteps));
      if (j == expSteps) begin
        chk(resCount == 4'(expK.size()), {req, " count"}, 32'(resCount), expK.size());
        chk(overflow == expOvf, {req, " R8 overflow"}, 32'(overflow), 32'(expOvf));
        for (int i = 0; i < expK.size(); i++) begin
          resRdIdx = 3'(i);
          #0.2;
          chk(resRdKey == expK[i], {req, " R10 key"}, resRdKey, expK[i]);
          chk(resRdVal == expV[i], {req, " value"}, resRdVal, expV[i]);
        end
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", 32'(busy), 0);
    chk(!done, "R1 done", 32'(done), 0);
    chk(resCount == 0, "R1 count", 32'(resCount), 0);
    chk(!overflow, "R1 overflow", 32'(overflow), 0);

    // R2 loading: A = 10,20,30,40,50 ; B = 20,35,50,60
    for (int i = 0; i < 5; i++) loadSrc(1'b0, i, 32'(10 * (i + 1)), 32'(100 + i));
    loadSrc(1'b1, 0, 32'd20, 32'd900);
    loadSrc(1'b1, 1, 32'd35, 32'd901);
    loadSrc(1'b1, 2, 32'd50, 32'd902);
    loadSrc(1'b1, 3, 32'd60, 32'd903);

    runOp("R3 union",      0, 5, 4, 32'd0, 1'b0);
    runOp("R4 intersect",  1, 5, 4, 32'd0, 1'b0);
    runOp("R5 difference", 2, 5, 4, 32'd0, 1'b0);
    runOp("R6 lt",         3, 5, 4, 32'd30, 1'b0);
    runOp("R6 gt",         4, 5, 4, 32'd30, 1'b0);
    runOp("R6 le",         5, 5, 4, 32'd30, 1'b0);
    runOp("R6 ge",         6, 5, 4, 32'd30, 1'b0);
    runOp("R6 ge all",     6, 5, 4, 32'd5, 1'b0);
    runOp("R6 code7",      7, 5, 4, 32'd0, 1'b0);
    runOp("R3 union emptyB", 0, 5, 0, 32'd0, 1'b0);
    runOp("R4 intersect emptyA", 1, 0, 4, 32'd0, 1'b0);

    // R8 exact fill without overflow: 4 + 4 distinct keys
    for (int i = 0; i < 8; i++) loadSrc(1'b0, i, 32'(2 * i + 1), 32'(200 + i));
    for (int i = 0; i < 8; i++) loadSrc(1'b1, i, 32'(2 * i + 2), 32'(300 + i));
    runOp("R8 exact fill", 0, 4, 4, 32'd0, 1'b0);
    // R8 overflow, disturbed by R2/R9 stimulus while busy
    runOp("R8 overflow", 0, 8, 8, 32'd0, 1'b1);
    // R2 A entry 0 must be unchanged after the ignored write
    runOp("R2 after busy write", 3, 8, 8, 32'd4, 1'b0);
    runOp("R9 rerun", 2, 8, 8, 32'd0, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule